// File: doc/BRIEF.md
# Bus Privilege Access Checker

This block sits between the point where the system bus grants a master and a space of peripheral and memory regions. It checks each transfer before it can select a target. The check combines the privilege level the transfer is treated with (supervisor or user) and its reference type (instruction fetch, operand read or operand write). A master trust register sets, for each bus master, whether the privilege it signals is believed or whether it is pushed down to user level. A table of region permission entries then gives, for each region, the fetch, read and write rights of each privilege level.

A transfer that is allowed is registered and sent out one cycle later with a one-hot target select. A transfer that is refused never selects a target. Instead the error output pulses for that one cycle. The topmost region holds the system control and configuration registers, including this block's own registers, and user-level transfers to it are always refused. A configuration write port, assumed to be reached only from supervisor code, programs both the trust register and the region table.

Top module: `bus_priv_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_err` and `tgt_valid` are 0 and `tgt_sel` is all zeros. After reset every region grants the supervisor fetch, read and write, and denies the user all three.
- R2: `req_kind` encodes the reference type as 0 = instruction fetch, 1 = operand read, 2 = operand write. Code 3 is refused at every privilege level.
- R3: A fetch is allowed only when the execute bit of the effective level is set in the region's entry. Read and write are judged by their own bits, so a region can allow reads and refuse fetches.
- R4: When a master's trust bit is 0, a transfer that signals supervisor is judged with the user permissions.
- R5: After reset the trust bit of every master is 1, so a signalled supervisor transfer is judged as supervisor.
- R6: An allowed request in cycle n gives `tgt_valid`=1 in cycle n+1, with `tgt_sel` one-hot on the decoded region and `tgt_addr` and `tgt_kind` equal to the request's values. `rsp_err` stays 0.
- R7: A refused request in cycle n gives `rsp_err`=1 in cycle n+1 only, with `tgt_valid`=0 and `tgt_sel` all zeros. With no request, both outputs are 0 in the next cycle.
- R8: A user-level transfer to the top region (index 7) is refused whatever its permission entry holds.
- R9: A configuration write in the same cycle as a request does not change that request's outcome. It applies from the next request on.
- R10: The region index is the top 3 bits of `req_addr`. The lower address bits play no part in the decision.
- R11: With `cfg_tgt`=1, a write stores `cfg_wdata[5:3]` as the supervisor rights and `cfg_wdata[2:0]` as the user rights of region `cfg_idx`. Within each triple, bit 0 is read, bit 1 is write and bit 2 is execute. With `cfg_tgt`=0, a write loads `cfg_wdata[3:0]` as the trust bits, with bit i belonging to master i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer is presented this cycle |
| req_master | input | 2 | Index of the requesting master |
| req_addr | input | 16 | Transfer address |
| req_sup | input | 1 | Privilege signalled by the master (1 = supervisor) |
| req_kind | input | 2 | Reference type: 0 fetch, 1 read, 2 write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 1 | 0 = trust register, 1 = region table |
| cfg_idx | input | 3 | Region index for table writes |
| cfg_wdata | input | 6 | Configuration write data |
| tgt_valid | output | 1 | Allowed transfer forwarded this cycle |
| tgt_sel | output | 8 | One-hot select of the target region |
| tgt_addr | output | 16 | Forwarded address |
| tgt_kind | output | 2 | Forwarded reference type |
| rsp_err | output | 1 | One-cycle error response for a refused transfer |

## Verification
The bench aims at several errors. It sends supervisor-signalled requests from untrusted masters; a design that ignored the trust bit would let them through. It sends user transfers to the control region after its entry has been opened to the user; a missing override would select a target there. It programs the table in the same cycle as a request to the same region; a design that read the new entry at once would change that request's outcome. It also issues fetches to regions that allow read but not execute, and the reserved type code, which catch decoders that merge fetch with read or treat code 3 as a write.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    // rights triple: bit0 read, bit1 write, bit2 execute
    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;

    typedef struct packed {
        logic [2:0] sup;
        logic [2:0] usr;
    } perm_t;

    localparam perm_t PERM_RESET = '{sup: 3'b111, usr: 3'b000};

    function automatic logic right_for_kind(input logic [2:0] rights, input kind_e kind);
        case (kind)
            KIND_FETCH: right_for_kind = rights[RIGHT_EX];
            KIND_READ:  right_for_kind = rights[RIGHT_RD];
            KIND_WRITE: right_for_kind = rights[RIGHT_WR];
            default:    right_for_kind = 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] rights_for_level(input perm_t p, input logic sup);
        rights_for_level = sup ? p.sup : p.usr;
    endfunction

endpackage

// File: rtl/bpc_master_trust.sv
module bpc_master_trust #(
    parameter int N_MASTERS = 4,
    parameter int CFG_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [N_MASTERS-1:0] trust
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trust <= '1;
        end else if (wr_en) begin
            trust <= wr_data[N_MASTERS-1:0];
        end
    end
endmodule

// File: rtl/bpc_region_table.sv
module bpc_region_table
    import bpc_pkg::*;
#(
    parameter int N_REGIONS = 8,
    parameter int CFG_W     = 6,
    localparam int REG_W    = $clog2(N_REGIONS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_idx,
    input  logic [CFG_W-1:0]            wr_data,
    output perm_t [N_REGIONS-1:0]       table_q
);
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[g] <= PERM_RESET;
            end else if (wr_en && (wr_idx == REG_W'(g))) begin
                table_q[g] <= '{sup: wr_data[5:3], usr: wr_data[2:0]};
            end
        end
    end
endmodule

// File: rtl/bpc_decide.sv
module bpc_decide
    import bpc_pkg::*;
#(
    parameter int N_REGIONS = 8,
    localparam int REG_W    = $clog2(N_REGIONS)
) (
    input  perm_t [N_REGIONS-1:0] table_q,
    input  logic [REG_W-1:0]      region,
    input  logic                  sup_eff,
    input  logic [1:0]            kind,
    output logic                  allow
);
    localparam logic [REG_W-1:0] CTRL_REGION = REG_W'(N_REGIONS - 1);

    logic [2:0] rights;
    logic       ctrl_block;

    always_comb begin
        rights     = rights_for_level(table_q[region], sup_eff);
        ctrl_block = !sup_eff && (region == CTRL_REGION);
        allow      = right_for_kind(rights, kind_e'(kind)) && !ctrl_block;
    end
endmodule

// File: rtl/bus_priv_checker.sv
module bus_priv_checker
    import bpc_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int N_REGIONS = 8,
    parameter int ADDR_W    = 16,
    localparam int MST_W    = $clog2(N_MASTERS),
    localparam int REG_W    = $clog2(N_REGIONS),
    localparam int CFG_W    = (N_MASTERS > 6) ? N_MASTERS : 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [MST_W-1:0]     req_master,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_sup,
    input  logic [1:0]           req_kind,
    input  logic                 cfg_we,
    input  logic                 cfg_tgt,
    input  logic [REG_W-1:0]     cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic                 tgt_valid,
    output logic [N_REGIONS-1:0] tgt_sel,
    output logic [ADDR_W-1:0]    tgt_addr,
    output logic [1:0]           tgt_kind,
    output logic                 rsp_err
);
    logic [N_MASTERS-1:0]  trust;
    perm_t [N_REGIONS-1:0] table_q;
    logic [REG_W-1:0]      region;
    logic                  sup_eff;
    logic                  allow;

    bpc_master_trust #(.N_MASTERS(N_MASTERS), .CFG_W(CFG_W)) u_trust (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && !cfg_tgt),
        .wr_data (cfg_wdata),
        .trust   (trust)
    );

    bpc_region_table #(.N_REGIONS(N_REGIONS), .CFG_W(CFG_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && cfg_tgt),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .table_q (table_q)
    );

    assign region  = req_addr[ADDR_W-1 -: REG_W];
    assign sup_eff = req_sup && trust[req_master];

    bpc_decide #(.N_REGIONS(N_REGIONS)) u_decide (
        .table_q (table_q),
        .region  (region),
        .sup_eff (sup_eff),
        .kind    (req_kind),
        .allow   (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_valid <= 1'b0;
            tgt_sel   <= '0;
            tgt_addr  <= '0;
            tgt_kind  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            tgt_valid <= req_valid && allow;
            rsp_err   <= req_valid && !allow;
            tgt_sel   <= (req_valid && allow) ? (N_REGIONS'(1) << region) : '0;
            if (req_valid && allow) begin
                tgt_addr <= req_addr;
                tgt_kind <= req_kind;
            end
        end
    end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int N_MASTERS = 4,
    parameter int N_REGIONS = 8,
    parameter int ADDR_W    = 16,
    localparam int MST_W    = $clog2(N_MASTERS),
    localparam int REG_W    = $clog2(N_REGIONS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [MST_W-1:0]     req_master,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_sup,
    input logic [1:0]           req_kind,
    input logic                 tgt_valid,
    input logic [N_REGIONS-1:0] tgt_sel,
    input logic                 rsp_err
);
    // R7: refused and forwarded never coincide
    a_r7_err_excludes_select: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (!tgt_valid && tgt_sel == '0));

    // R6: a forwarded transfer selects exactly one region
    a_r6_select_onehot: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> $countones(tgt_sel) == 1);

    // R6: no select without a forwarded transfer
    a_r6_select_quiet: assert property (@(posedge clk) disable iff (rst)
        !tgt_valid |-> tgt_sel == '0);

    // R7: an idle cycle produces neither response next cycle
    a_r7_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_err && !tgt_valid));

    // R7: every request produces exactly one response next cycle
    a_r7_one_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_err ^ tgt_valid));

    // R8: user-signalled transfers to the control region never go out
    a_r8_ctrl_guard: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_sup && req_addr[ADDR_W-1 -: REG_W] == REG_W'(N_REGIONS - 1))
        |=> rsp_err);

    // R2: reserved type code always refused
    a_r2_reserved_kind: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd3) |=> rsp_err);
endmodule

bind bus_priv_checker bpc_checker #(
    .N_MASTERS(N_MASTERS), .N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_master (req_master),
    .req_addr   (req_addr),
    .req_sup    (req_sup),
    .req_kind   (req_kind),
    .tgt_valid  (tgt_valid),
    .tgt_sel    (tgt_sel),
    .rsp_err    (rsp_err)
);

// File: tb/bus_priv_checker_test.sv
`timescale 1ns/1ps
module bus_priv_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_master = '0;
    logic [15:0] req_addr = '0;
    logic        req_sup = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_tgt = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [5:0]  cfg_wdata = '0;
    logic        tgt_valid;
    logic [7:0]  tgt_sel;
    logic [15:0] tgt_addr;
    logic [1:0]  tgt_kind;
    logic        rsp_err;

    always #10 clk = ~clk;

    bus_priv_checker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
        .req_addr(req_addr), .req_sup(req_sup), .req_kind(req_kind),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
        .tgt_kind(tgt_kind), .rsp_err(rsp_err)
    );

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    bit [3:0] m_trust;
    bit [5:0] m_table [8];

    // expected outputs for the next negedge
    bit          e_valid, e_err;
    bit [7:0]    e_sel;
    bit [15:0]   e_addr;
    bit [1:0]    e_kind;
    string       e_tag;

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_allow(input bit [1:0] m, input bit [15:0] a,
                                       input bit s, input bit [1:0] k);
        bit [2:0] reg_i = a[15:13];
        bit       eff   = s && m_trust[m];
        bit [2:0] r     = eff ? m_table[reg_i][5:3] : m_table[reg_i][2:0];
        if (k == 2'd3) return 1'b0;
        if (!eff && reg_i == 3'd7) return 1'b0;
        case (k)
            2'd0: return r[2];
            2'd1: return r[0];
            default: return r[1];
        endcase
    endfunction

    function automatic string pick_tag(input bit [1:0] m, input bit [15:0] a,
                                       input bit s, input bit [1:0] k, input bit al);
        if (k == 2'd3) return "R2";
        if (!(s && m_trust[m]) && a[15:13] == 3'd7) return "R8";
        if (s && !m_trust[m]) return "R4";
        if (k == 2'd0) return "R3";
        return al ? "R6" : "R7";
    endfunction

    task automatic compare_outputs();
        string t = e_tag;
        check({t, " err"},   rsp_err == e_err,     rsp_err,   e_err);
        check({t, " valid"}, tgt_valid == e_valid, tgt_valid, e_valid);
        check({t, " sel"},   tgt_sel == e_sel,     tgt_sel,   e_sel);
        if (e_valid) begin
            check({t, " addr"}, tgt_addr == e_addr, tgt_addr, e_addr);
            check({t, " kind"}, tgt_kind == e_kind, tgt_kind, e_kind);
        end
    endtask

    // one cycle: check previous result, then present new stimulus
    task automatic step(input bit v, input bit [1:0] m, input bit [15:0] a,
                        input bit s, input bit [1:0] k,
                        input bit we, input bit tg, input bit [2:0] idx,
                        input bit [5:0] wd, input string tag_force);
        bit al;
        @(negedge clk);
        compare_outputs();
        al      = v && model_allow(m, a, s, k);
        e_valid = al;
        e_err   = v && !al;
        e_sel   = al ? (8'd1 << a[15:13]) : 8'd0;
        e_addr  = a;
        e_kind  = k;
        e_tag   = (tag_force != "") ? tag_force :
                  (v ? pick_tag(m, a, s, k, al) : "R7");
        if (we) begin
            if (tg) m_table[idx] = wd;
            else    m_trust = wd[3:0];
        end
        req_valid = v; req_master = m; req_addr = a; req_sup = s; req_kind = k;
        cfg_we = we; cfg_tgt = tg; cfg_idx = idx; cfg_wdata = wd;
    endtask

    initial begin
        #(200000 * 20);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        m_trust = 4'hF;
        foreach (m_table[i]) m_table[i] = 6'b111_000;
        e_valid = 0; e_err = 0; e_sel = 0; e_addr = 0; e_kind = 0; e_tag = "R1";
        repeat (3) @(negedge clk);
        check("R1 reset err",   rsp_err == 0,   rsp_err,   0);
        check("R1 reset valid", tgt_valid == 0, tgt_valid, 0);
        check("R1 reset sel",   tgt_sel == 0,   tgt_sel,   0);
        rst = 1'b0;

        // R1: first cycle after reset quiet, defaults: user denied, supervisor allowed
        step(1, 0, 16'h0010, 0, 2'd1, 0, 0, 0, 0, "R1");
        step(1, 0, 16'h0010, 1, 2'd0, 0, 0, 0, 0, "R1");
        step(1, 1, 16'h2345, 1, 2'd2, 0, 0, 0, 0, "R1");
        // R5: every master trusted after reset
        step(1, 3, 16'h4000, 1, 2'd1, 0, 0, 0, 0, "R5");
        step(1, 2, 16'h6000, 1, 2'd0, 0, 0, 0, 0, "R5");
        // R11: open region 2 to user read only (usr=001), sup keep all
        step(0, 0, 0, 0, 0, 1, 1, 3'd2, 6'b111_001, "R11");
        step(1, 0, 16'h4ABC, 0, 2'd1, 0, 0, 0, 0, "R11");
        // R3: user fetch on read-only region is refused
        step(1, 0, 16'h4ABC, 0, 2'd0, 0, 0, 0, 0, "R3");
        step(1, 0, 16'h4002, 0, 2'd2, 0, 0, 0, 0, "R11");
        // R10: lower bits irrelevant
        step(1, 1, 16'h5FFF, 0, 2'd1, 0, 0, 0, 0, "R10");
        step(1, 1, 16'h6000, 0, 2'd1, 0, 0, 0, 0, "R10");
        // R9: write closes region 2 in the same cycle as a user read there
        step(1, 2, 16'h4100, 0, 2'd1, 1, 1, 3'd2, 6'b111_000, "R9");
        step(1, 2, 16'h4100, 0, 2'd1, 0, 0, 0, 0, "R9");
        // R4: untrust master 1, supervisor claims judged as user
        step(0, 0, 0, 0, 0, 1, 0, 0, 6'b001101, "R11");
        step(1, 1, 16'h0000, 1, 2'd1, 0, 0, 0, 0, "R4");
        step(1, 0, 16'h0000, 1, 2'd1, 0, 0, 0, 0, "R4");
        // R8: open region 7 to user fully, still refused for user
        step(0, 0, 0, 0, 0, 1, 1, 3'd7, 6'b111_111, "R8");
        step(1, 0, 16'hE000, 0, 2'd1, 0, 0, 0, 0, "R8");
        step(1, 1, 16'hF00F, 1, 2'd2, 0, 0, 0, 0, "R8");
        step(1, 0, 16'hE004, 1, 2'd2, 0, 0, 0, 0, "R8");
        // R2: reserved code refused even for trusted supervisor
        step(1, 0, 16'h0100, 1, 2'd3, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");

        // constrained random with fixed seed
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            bit        v  = ($urandom % 4) != 0;
            bit [1:0]  m  = 2'($urandom);
            bit [15:0] a  = 16'($urandom);
            bit        s  = 1'($urandom);
            bit [1:0]  k  = (($urandom % 16) == 0) ? 2'd3 : 2'($urandom % 3);
            bit        we = ($urandom % 6) == 0;
            bit        tg = ($urandom % 3) != 0;
            bit [2:0]  ix = 3'($urandom);
            bit [5:0]  wd = 6'($urandom);
            step(v, m, a, s, k, we, tg, ix, wd, "");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        @(negedge clk);
        compare_outputs();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule